// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three identical 16-bit up-counters behind a small 32-bit register bus. All channels share one timer input, presented as a clock-enable strobe (`tick_en`) in the bus clock domain. Each channel can divide that strobe by a programmable power of two before counting. A channel either runs free and wraps from 0xFFFF to 0, or runs in interval mode and returns to 0 after it reaches a programmed value. Either event raises a status flag. The flags can be masked onto a per-channel interrupt line and are cleared by reading them.

Software configures a channel by writing its clock setup, interval and interrupt mask, then writing the counter control word. A single control write can clear the stop bit and set the self-clearing restart bit together, which zeroes the count and starts it in the same access. The register groups are laid out with the three channels interleaved at a 4-byte stride. Channel 0 uses the base offsets: 0x00 clock setup, 0x0C counter control, 0x18 count (read-only), 0x24 interval, 0x54 status (read-only, clear on read), 0x60 interrupt mask. Channels 1 and 2 add 4 and 8 to these offsets.

Top module: `ttc_top`

## Requirements
- R1: After reset, counter control reads 0x21 (stopped, bit 5 set), and the count, clock setup, interval, status and mask all read 0. Every interrupt line is low.
- R2: With control bit 0 clear, the count rises by one on each counting step. With bit 0 set the count holds. A control write acts from the following cycle, so the step in the cycle of the write still uses the old stop state.
- R3: Writing control bit 4 as 1 zeroes the count in the cycle of the write, whether the counter is running or stopped. Bit 4 always reads back as 0.
- R4: When clock setup bit 0 is 1, a counting step occurs once every 2^(N+1) `tick_en` pulses, where N is clock setup bits [4:1]. A restart zeroes the divider. When bit 0 is 0, every `tick_en` pulse is a step.
- R5: When `tick_en` is low, no channel's count changes.
- R6: In free-running mode (control bit 1 clear), a step at 0xFFFF wraps the count to 0 and sets status bit 4.
- R7: In interval mode (control bit 1 set), a step taken while the count equals the interval value returns the count to 0 and sets status bit 0. Interval values from 1 through 0xFFFE work.
- R8: A status read returns the pending flags (bit 0 interval, bit 4 wrap) and clears them at the end of the read cycle. A flag set in the same cycle as a clearing read stays pending.
- R9: `irq[c]` is high exactly when a status flag of channel c is set and its mask bit, in the same bit position, is 1.
- R10: Channels are independent. A register of channel c sits at its group offset plus 4*c. Offsets that decode to no register read 0, and writes to the read-only count and status registers change nothing.
- R11: Control bit 5 is stored and reads back, and it has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Timer input strobe; one pulse is one input clock |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; a status read clears that status |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_re`, 0 otherwise |
| irq | output | 3 | Per-channel interrupt |

## Verification
The bench targets the cycle of a control write. A design that let a stop take effect at once would hold the count one lower, and a design that failed to restart a stopped counter would leave a stale count. It also reads status in the same cycle that the interval match sets it; a design that lets the clear win would lose that interrupt and return 0 on the next read. The wrap at 0xFFFF and an interval of 0xFFFE run on two channels at once. An off-by-one in the compare, or a wrap flag raised in interval mode, shows up as a wrong count or a wrong status bit. The prescaler is checked at divide-by-2, 8 and 2048, where an exponent off by one halves or doubles the count.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  // Base byte offsets of each register group (channel 0); channels add STRIDE*c.
  localparam int OFS_CLK  = 'h00;
  localparam int OFS_CTL  = 'h0C;
  localparam int OFS_CNT  = 'h18;
  localparam int OFS_IVL  = 'h24;
  localparam int OFS_ISR  = 'h54;
  localparam int OFS_IEN  = 'h60;
  localparam int STRIDE   = 4;

  // Counter control bit positions.
  localparam int CTL_STOP    = 0;
  localparam int CTL_IMODE   = 1;
  localparam int CTL_RESTART = 4;
  localparam int CTL_WDIS    = 5;
  localparam int CTL_W       = 6;

  // Status / mask bit positions.
  localparam int FLG_IVL = 0;
  localparam int FLG_OVF = 4;
  localparam int FLG_W   = 5;

  // Prescaler select field width in clock setup (bits [PSC_W:1]).
  localparam int PSC_W = 4;
endpackage

// File: rtl/ttc_prescaler.sv
module ttc_prescaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             clear,
  input  logic             psc_en,
  input  logic [SEL_W-1:0] psc_sel,
  output logic             step
);
  localparam int PRE_W = 2 ** SEL_W;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W:0]   lim_m1;

  always_comb begin
    lim_m1 = ({{PRE_W{1'b0}}, 1'b1} << (psc_sel + 1)) - 1'b1;
    pre_d  = pre_q;
    step   = 1'b0;
    if (clear) begin
      pre_d = '0;
    end else if (run && tick_en) begin
      if (!psc_en) begin
        step = 1'b1;
      end else if ({1'b0, pre_q} == lim_m1) begin
        pre_d = '0;
        step  = 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R4: a counting step only comes from an input pulse on a running channel
  assert_step_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (tick_en && run));
endmodule

// File: rtl/ttc_channel.sv
module ttc_channel
  import ttc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic [CNT_W-1:0]   wdata,
  input  logic               wr_clk,
  input  logic               wr_ctl,
  input  logic               wr_ivl,
  input  logic               wr_ien,
  input  logic               rd_isr,
  output logic [PSC_W:0]     clk_rd,
  output logic [CTL_W-1:0]   ctl_rd,
  output logic [CNT_W-1:0]   cnt_rd,
  output logic [CNT_W-1:0]   ivl_rd,
  output logic [FLG_W-1:0]   isr_rd,
  output logic [FLG_W-1:0]   ien_rd,
  output logic               irq
);
  // Register state
  logic [PSC_W:0]   clk_q, clk_d;
  logic             stop_q, stop_d;
  logic             imode_q, imode_d;
  logic             wdis_q, wdis_d;
  logic [CNT_W-1:0] ivl_q, ivl_d;
  logic [1:0]       ien_q, ien_d;   // [0] interval, [1] wrap
  logic [1:0]       isr_q, isr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic restart, step, set_ivl, set_ovf;

  assign restart = wr_ctl & wdata[CTL_RESTART];

  ttc_prescaler #(.SEL_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .run     (~stop_q),
    .clear   (restart),
    .psc_en  (clk_q[0]),
    .psc_sel (clk_q[PSC_W:1]),
    .step    (step)
  );

  // Configuration next state
  always_comb begin
    clk_d   = wr_clk ? wdata[PSC_W:0] : clk_q;
    stop_d  = wr_ctl ? wdata[CTL_STOP]  : stop_q;
    imode_d = wr_ctl ? wdata[CTL_IMODE] : imode_q;
    wdis_d  = wr_ctl ? wdata[CTL_WDIS]  : wdis_q;
    ivl_d   = wr_ivl ? wdata : ivl_q;
    ien_d   = wr_ien ? {wdata[FLG_OVF], wdata[FLG_IVL]} : ien_q;
  end

  // Counter and status next state
  always_comb begin
    cnt_d   = cnt_q;
    set_ivl = 1'b0;
    set_ovf = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (step) begin
      if (imode_q && (cnt_q == ivl_q)) begin
        cnt_d   = '0;
        set_ivl = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == {CNT_W{1'b1}}) set_ovf = 1'b1;
      end
    end
    isr_d = (isr_q & ~{2{rd_isr}}) | {set_ovf, set_ivl};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q   <= '0;
      stop_q  <= 1'b1;
      imode_q <= 1'b0;
      wdis_q  <= 1'b1;
      ivl_q   <= '0;
      ien_q   <= '0;
      isr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      clk_q   <= clk_d;
      stop_q  <= stop_d;
      imode_q <= imode_d;
      wdis_q  <= wdis_d;
      ivl_q   <= ivl_d;
      ien_q   <= ien_d;
      isr_q   <= isr_d;
      cnt_q   <= cnt_d;
    end
  end

  assign clk_rd = clk_q;
  assign ctl_rd = {wdis_q, 1'b0, 2'b00, imode_q, stop_q};
  assign cnt_rd = cnt_q;
  assign ivl_rd = ivl_q;
  assign isr_rd = {isr_q[1], 3'b000, isr_q[0]};
  assign ien_rd = {ien_q[1], 3'b000, ien_q[0]};
  assign irq    = |(isr_q & ien_q);

  // R3: a restart write leaves the count at zero
  assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
  // R2: a stopped counter holds its value
  assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !restart) |=> $stable(cnt_q));
  // R5: no input pulse, no count change
  assert_tick_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !restart) |=> $stable(cnt_q));
  // R7: step at the interval value returns to zero and flags it
  assert_ivl_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && imode_q && (cnt_q == ivl_q) && !restart) |=> ((cnt_q == '0) && isr_q[0]));
  // R8: a flag raised during a clearing read survives
  assert_pending_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ovf && rd_isr) |=> isr_q[1]);
  // R9: an unmasked channel never interrupts
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 2'b00) |-> !irq);
endmodule

// File: rtl/ttc_top.sv
module ttc_top
  import ttc_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^bus_wdata[DATA_W-1:CNT_W];

  logic [PSC_W:0]   clk_rd [NUM_CH];
  logic [CTL_W-1:0] ctl_rd [NUM_CH];
  logic [CNT_W-1:0] cnt_rd [NUM_CH];
  logic [CNT_W-1:0] ivl_rd [NUM_CH];
  logic [FLG_W-1:0] isr_rd [NUM_CH];
  logic [FLG_W-1:0] ien_rd [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CLK = ADDR_W'(OFS_CLK + STRIDE * c);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(OFS_CTL + STRIDE * c);
    localparam logic [ADDR_W-1:0] A_IVL = ADDR_W'(OFS_IVL + STRIDE * c);
    localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'(OFS_ISR + STRIDE * c);
    localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(OFS_IEN + STRIDE * c);

    ttc_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .tick_en (tick_en),
      .wdata   (bus_wdata[CNT_W-1:0]),
      .wr_clk  (bus_we && (bus_addr == A_CLK)),
      .wr_ctl  (bus_we && (bus_addr == A_CTL)),
      .wr_ivl  (bus_we && (bus_addr == A_IVL)),
      .wr_ien  (bus_we && (bus_addr == A_IEN)),
      .rd_isr  (bus_re && (bus_addr == A_ISR)),
      .clk_rd  (clk_rd[c]),
      .ctl_rd  (ctl_rd[c]),
      .cnt_rd  (cnt_rd[c]),
      .ivl_rd  (ivl_rd[c]),
      .isr_rd  (isr_rd[c]),
      .ien_rd  (ien_rd[c]),
      .irq     (irq[c])
    );
  end

  // Read mux: only decoded offsets contribute, everything else reads 0
  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (bus_addr == ADDR_W'(OFS_CLK + STRIDE * i)) bus_rdata = DATA_W'(clk_rd[i]);
        if (bus_addr == ADDR_W'(OFS_CTL + STRIDE * i)) bus_rdata = DATA_W'(ctl_rd[i]);
        if (bus_addr == ADDR_W'(OFS_CNT + STRIDE * i)) bus_rdata = DATA_W'(cnt_rd[i]);
        if (bus_addr == ADDR_W'(OFS_IVL + STRIDE * i)) bus_rdata = DATA_W'(ivl_rd[i]);
        if (bus_addr == ADDR_W'(OFS_ISR + STRIDE * i)) bus_rdata = DATA_W'(isr_rd[i]);
        if (bus_addr == ADDR_W'(OFS_IEN + STRIDE * i)) bus_rdata = DATA_W'(ien_rd[i]);
      end
    end
  end

  // R10: the read port is silent outside read cycles
  assert_idle_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_re |-> (bus_rdata == '0));
endmodule

// File: tb/ttc_top_test.sv
`timescale 1ns/1ps
module ttc_top_test;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int n_checks;
  int n_fail;
  bit done;

  ttc_top uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset;
    rd_check("R1 ctl0 reset", 8'h0C, 32'h21);
    rd_check("R1 ctl2 reset", 8'h14, 32'h21);
    rd_check("R1 cnt1 reset", 8'h1C, 32'h0);
    rd_check("R1 clk0 reset", 8'h00, 32'h0);
    rd_check("R1 ivl2 reset", 8'h2C, 32'h0);
    rd_check("R1 isr0 reset", 8'h54, 32'h0);
    rd_check("R1 ien1 reset", 8'h64, 32'h0);
    check("R1 irq reset", {29'd0, irq}, 32'h0);
  endtask

  task automatic t_map;
    rd_check("R10 unused offset", 8'h30, 32'h0);
    rd_check("R10 misaligned offset", 8'h03, 32'h0);
    wr(8'h20, 32'h5555);
    rd_check("R10 count write ignored", 8'h20, 32'h0);
    wr(8'h5C, 32'h11);
    rd_check("R10 status write ignored", 8'h5C, 32'h0);
    wr(8'h2C, 32'h1234);
    rd_check("R10 ivl2 stored", 8'h2C, 32'h1234);
    rd_check("R10 ivl0 untouched", 8'h24, 32'h0);
  endtask

  task automatic t_stop;
    wr(8'h0C, 32'h10);                       // restart + run
    wait_edges(5);
    rd_check("R2 counts up", 8'h18, 32'd5);  // read edge -> 6
    wr(8'h0C, 32'h01);                       // stop; this edge still counts -> 7
    wait_edges(5);
    rd_check("R2 holds when stopped", 8'h18, 32'd7);
    rd_check("R3 restart bit reads 0", 8'h0C, 32'h01);
    wr(8'h0C, 32'h11);                       // restart while stopped
    wait_edges(3);
    rd_check("R3 restart while stopped", 8'h18, 32'd0);
  endtask

  task automatic t_prescale;
    wr(8'h00, 32'h05);                       // enable, N=2 -> /8
    wr(8'h0C, 32'h10);
    wait_edges(20);
    rd_check("R4 divide by 8", 8'h18, 32'd2);
    wr(8'h00, 32'h01);                       // N=0 -> /2
    wr(8'h0C, 32'h10);
    wait_edges(10);
    rd_check("R4 divide by 2", 8'h18, 32'd5);
    wr(8'h00, 32'h15);                       // N=10 -> /2048
    wr(8'h0C, 32'h10);
    wait_edges(4100);
    rd_check("R4 divide by 2048", 8'h18, 32'd2);
    wr(8'h00, 32'h00);
    wr(8'h0C, 32'h11);
  endtask

  task automatic t_tick;
    wr(8'h10, 32'h10);                       // ch1 restart + run
    tick_en = 1'b0;
    wait_edges(6);
    rd_check("R5 no pulses no count", 8'h1C, 32'd0);
    tick_en = 1'b1;
    wait_edges(4);
    rd_check("R5 counts with pulses", 8'h1C, 32'd4);
    wr(8'h10, 32'h11);
  endtask

  task automatic t_wdis;
    wr(8'h14, 32'h30);                       // ch2 run, bit5, restart
    rd_check("R11 bit5 stored", 8'h14, 32'h20);
    wait_edges(3);
    rd_check("R11 bit5 no effect on count", 8'h20, 32'd4);
    wr(8'h14, 32'h11);
  endtask

  task automatic t_irq;
    wr(8'h68, 32'h01);                       // ch2 interval irq enable
    wr(8'h2C, 32'd3);
    wr(8'h14, 32'h12);                       // interval mode, restart, run
    wait_edges(3);
    check("R9 irq low before match", {31'd0, irq[2]}, 32'd0);
    rd_check("R7 reaches interval", 8'h20, 32'd3);   // edge: 3 -> 0, flag
    check("R9 irq raised", {31'd0, irq[2]}, 32'd1);
    rd_check("R7 count back to 0", 8'h20, 32'd0);
    rd_check("R8 status returns flag", 8'h5C, 32'h01);
    check("R9 irq drops after clear", {31'd0, irq[2]}, 32'd0);
    rd_check("R8 status cleared", 8'h5C, 32'h00);
    wr(8'h14, 32'h11);
    wr(8'h68, 32'h00);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    wr(8'h28, 32'd1);                        // ch1 interval 1
    wr(8'h10, 32'h12);
    wait_edges(1);                           // count 1, next edge flags
    rd_check("R8 read before flag", 8'h58, 32'h00);
    rd_check("R8 flag kept through clearing read", 8'h58, 32'h01);
    check("R9 masked flag no irq", {31'd0, irq[1]}, 32'd0);
    rd_check("R8 cleared then idle", 8'h58, 32'h00);
    rd_check("R7 interval 1 flags again", 8'h58, 32'h01);
    wr(8'h10, 32'h11);
    rd(8'h58, v);
    rd(8'h58, v);
  endtask

  task automatic t_wrap;
    wr(8'h28, 32'hFFFE);                     // ch1 interval 0xFFFE
    wr(8'h0C, 32'h10);                       // ch0 free run: 0
    wr(8'h10, 32'h12);                       // ch1 interval: 0, ch0 1
    wait_edges(32'hFFFD);
    rd_check("R6 ch0 near top", 8'h18, 32'hFFFE);
    rd_check("R7 ch1 at 0xFFFE", 8'h1C, 32'hFFFE);
    rd_check("R6 ch0 wrapped to 0", 8'h18, 32'h0);
    rd_check("R7 ch1 back to 0", 8'h1C, 32'h1);
    rd_check("R6 wrap flag bit4", 8'h54, 32'h10);
    rd_check("R7 interval flag bit0 only", 8'h58, 32'h01);
    rd_check("R8 ch0 flag cleared", 8'h54, 32'h00);
    check("R9 irq stays low unmasked", {29'd0, irq}, 32'h0);
    rd_check("R10 ch2 unaffected", 8'h20, 32'h0);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; tick_en = 1'b1;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait_edges(3);
    t_reset;
    t_map;
    t_stop;
    t_prescale;
    t_tick;
    t_wdis;
    t_irq;
    t_same_cycle;
    t_wrap;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule